// File: doc/BRIEF.md
# Oscillator Control Word Updater

This block holds the trim state of a digitally controlled oscillator. The state is an 8-bit stage word and a 4-bit divider code. A frequency-lock loop measures the oscillator and, on each valid strobe, asks for one correction. A correction has a direction, up or down. It also has a size: fine, a step of one, or coarse, a step of 32 on bit 5 of the stage word. The lock loop uses the coarse step while the measured error is larger than fifteen percent in either direction.

Nothing writes the divider code directly. It moves by one only when a correction to the stage word carries out of bit 7 or borrows from it. The two registers therefore act as one chained number, with the divider code as its upper field. That upper field stops at nine. At the top or the bottom of the combined range the stage word clamps and a saturation flag reports the clamp. The updated words appear one clock after the strobe is sampled.

Top module: `osc_trim_updater`

## Requirements
- R1: After reset the stage word is 0x80, the divider code is 0, and both saturation flags are 0.
- R2: A valid strobe with `corr_up`=1 and `corr_coarse`=0 adds 1 to the stage word. With `corr_up`=0 and `corr_coarse`=0 it subtracts 1. The new value is visible after the next rising clock edge.
- R3: A valid strobe with `corr_coarse`=1 adds or subtracts 32 on the stage word.
- R4: An up correction that carries out of the stage word wraps the stage word modulo 256 and increments the divider code by one, provided the code is below nine.
- R5: A down correction that borrows wraps the stage word modulo 256 and decrements the divider code by one, provided the code is above zero.
- R6: An up correction that would carry while the divider code is nine leaves the divider code at nine, sets the stage word to 0xFF and sets `sat_high`.
- R7: A down correction that would borrow while the divider code is zero leaves the divider code at zero, sets the stage word to 0x00 and sets `sat_low`.
- R8: The flags describe the most recent applied correction. A correction that does not clamp clears both flags. Cycles with `corr_valid`=0 change neither the words nor the flags, whatever `corr_up` and `corr_coarse` are.
- R9: The divider code never exceeds nine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_valid | input | 1 | Apply one correction at this edge |
| corr_up | input | 1 | 1 = increase the control word, 0 = decrease it |
| corr_coarse | input | 1 | 1 = step of 32, 0 = step of 1 |
| stage_word | output | 8 | Oscillator stage control word |
| div_code | output | 4 | Binary divider code, 0 to 9 |
| sat_high | output | 1 | Last correction clamped at the top |
| sat_low | output | 1 | Last correction clamped at the bottom |

## Verification
Both words are outputs, so any wrong internal state shows at the ports one clock after the correction that caused it. A lost or doubled carry shifts the divider code by one, and the bench's combined-number model reports it at the very next sample. A wrong clamp boundary hides until the range limit is reached, so the bench drives the code to nine and to zero and checks that the words and flags hold there. Flag errors can persist silently across idle cycles, so the bench checks them after strobe-free gaps and after the first correction that does not clamp.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int STAGE_W_DEF   = 8;
  localparam int DIV_W_DEF     = 4;
  localparam int DIV_MAX_DEF   = 9;
  localparam int COARSE_BIT_DEF = 5;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } trim_dir_e;
endpackage

// File: rtl/trim_step_sel.sv
module trim_step_sel #(
  parameter int STAGE_W    = 8,
  parameter int COARSE_BIT = 5
) (
  input  logic               coarse_i,
  output logic [STAGE_W-1:0] step_o
);
  localparam logic [STAGE_W-1:0] FINE_STEP   = STAGE_W'(1);
  localparam logic [STAGE_W-1:0] COARSE_STEP = FINE_STEP << COARSE_BIT;

  assign step_o = coarse_i ? COARSE_STEP : FINE_STEP;
endmodule

// File: rtl/trim_chain_math.sv
module trim_chain_math
  import osc_trim_pkg::*;
#(
  parameter int STAGE_W = 8,
  parameter int DIV_W   = 4,
  parameter int DIV_MAX = 9
) (
  input  logic [STAGE_W-1:0] stage_i,
  input  logic [DIV_W-1:0]   div_i,
  input  trim_dir_e          dir_i,
  input  logic [STAGE_W-1:0] step_i,
  output logic [STAGE_W-1:0] nxt_stage_o,
  output logic [DIV_W-1:0]   nxt_div_o,
  output logic               clamp_hi_o,
  output logic               clamp_lo_o,
  output logic               carry_o,
  output logic               borrow_o,
  output logic               div_move_o
);
  localparam logic [DIV_W-1:0] DMAX = DIV_W'(DIV_MAX);

  function automatic logic [STAGE_W:0] add_ext(input logic [STAGE_W-1:0] a,
                                               input logic [STAGE_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [STAGE_W:0] sub_ext(input logic [STAGE_W-1:0] a,
                                               input logic [STAGE_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  logic [STAGE_W:0] sum_w, dif_w;
  logic             at_top, at_bot;

  always_comb begin
    sum_w    = add_ext(stage_i, step_i);
    dif_w    = sub_ext(stage_i, step_i);
    carry_o  = (dir_i == DIR_UP)   && sum_w[STAGE_W];
    borrow_o = (dir_i == DIR_DOWN) && dif_w[STAGE_W];
    at_top   = (div_i >= DMAX);
    at_bot   = (div_i == '0);

    nxt_stage_o = (dir_i == DIR_UP) ? sum_w[STAGE_W-1:0] : dif_w[STAGE_W-1:0];
    nxt_div_o   = at_top ? DMAX : div_i;
    clamp_hi_o  = 1'b0;
    clamp_lo_o  = 1'b0;

    if (carry_o) begin
      if (at_top) begin
        nxt_stage_o = '1;
        clamp_hi_o  = 1'b1;
      end else begin
        nxt_div_o = div_i + DIV_W'(1);
      end
    end else if (borrow_o) begin
      if (at_bot) begin
        nxt_stage_o = '0;
        clamp_lo_o  = 1'b1;
      end else begin
        nxt_div_o = nxt_div_o - DIV_W'(1);
      end
    end

    div_move_o = (carry_o && !at_top) || (borrow_o && !at_bot);
  end
endmodule

// File: rtl/osc_trim_updater.sv
module osc_trim_updater
  import osc_trim_pkg::*;
#(
  parameter int STAGE_W    = STAGE_W_DEF,
  parameter int DIV_W      = DIV_W_DEF,
  parameter int DIV_MAX    = DIV_MAX_DEF,
  parameter int COARSE_BIT = COARSE_BIT_DEF,
  parameter logic [STAGE_W-1:0] STAGE_RST = STAGE_W'(1) << (STAGE_W - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               corr_valid,
  input  logic               corr_up,
  input  logic               corr_coarse,
  output logic [STAGE_W-1:0] stage_word,
  output logic [DIV_W-1:0]   div_code,
  output logic               sat_high,
  output logic               sat_low
);
  localparam logic [DIV_W-1:0] DMAX = DIV_W'(DIV_MAX);

  logic [STAGE_W-1:0] step_w, nxt_stage_w;
  logic [DIV_W-1:0]   nxt_div_w;
  logic               clamp_hi_w, clamp_lo_w, carry_evt, borrow_evt, div_move;
  trim_dir_e          dir_w;

  assign dir_w = corr_up ? DIR_UP : DIR_DOWN;

  trim_step_sel #(.STAGE_W(STAGE_W), .COARSE_BIT(COARSE_BIT)) u_step (
    .coarse_i (corr_coarse),
    .step_o   (step_w)
  );

  trim_chain_math #(.STAGE_W(STAGE_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_math (
    .stage_i     (stage_word),
    .div_i       (div_code),
    .dir_i       (dir_w),
    .step_i      (step_w),
    .nxt_stage_o (nxt_stage_w),
    .nxt_div_o   (nxt_div_w),
    .clamp_hi_o  (clamp_hi_w),
    .clamp_lo_o  (clamp_lo_w),
    .carry_o     (carry_evt),
    .borrow_o    (borrow_evt),
    .div_move_o  (div_move)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_word <= STAGE_RST;
      div_code   <= '0;
      sat_high   <= 1'b0;
      sat_low    <= 1'b0;
    end else if (corr_valid) begin
      stage_word <= nxt_stage_w;
      div_code   <= nxt_div_w;
      sat_high   <= clamp_hi_w;
      sat_low    <= clamp_lo_w;
    end
  end

  // R9
  div_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_code <= DMAX);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_valid |=> $stable(stage_word) && $stable(div_code)
                    && $stable(sat_high) && $stable(sat_low));

  // R6
  sat_high_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_high |-> (stage_word == '1) && (div_code == DMAX) && !sat_low);

  // R7
  sat_low_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_low |-> (stage_word == '0) && (div_code == '0));

  // R4
  div_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid && carry_evt && div_move |=> div_code == $past(div_code) + DIV_W'(1));

  // R5
  div_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid && borrow_evt && div_move |=> div_code == $past(div_code) - DIV_W'(1));

  // R2
  div_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid && !div_move |=> $stable(div_code));
endmodule

// File: tb/sim_osc_trim_updater.sv
module sim_osc_trim_updater;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       corr_valid = 1'b0, corr_up = 1'b0, corr_coarse = 1'b0;
  logic [7:0] stage_word;
  logic [3:0] div_code;
  logic       sat_high, sat_low;

  int n_checks = 0;
  int n_fail   = 0;
  int m_total;
  bit m_hi, m_lo;
  localparam int M_MAX = 9 * 256 + 255;

  always #4 clk = ~clk;

  osc_trim_updater u0 (
    .clk(clk), .rst_n(rst_n), .corr_valid(corr_valid), .corr_up(corr_up),
    .corr_coarse(corr_coarse), .stage_word(stage_word), .div_code(div_code),
    .sat_high(sat_high), .sat_low(sat_low)
  );

  task automatic check(input string tag);
    int exp_stage = m_total % 256;
    int exp_div   = m_total / 256;
    n_checks++;
    if (stage_word !== 8'(exp_stage) || div_code !== 4'(exp_div) ||
        sat_high !== m_hi || sat_low !== m_lo) begin
      n_fail++;
      $display("FAIL %s: got stage=%h div=%0d hi=%b lo=%b, expected stage=%h div=%0d hi=%b lo=%b",
               tag, stage_word, div_code, sat_high, sat_low,
               8'(exp_stage), exp_div, m_hi, m_lo);
    end
  endtask

  task automatic apply(input bit up, input bit coarse);
    int step = coarse ? 32 : 1;
    int t;
    string tag;
    tag = coarse ? "R3" : "R2";
    if ((m_total % 256) + (up ? step : -step) > 255) tag = "R4";
    if ((m_total % 256) + (up ? step : -step) < 0)   tag = "R5";
    t = up ? m_total + step : m_total - step;
    m_hi = 1'b0;
    m_lo = 1'b0;
    if (t > M_MAX) begin t = M_MAX; m_hi = 1'b1; tag = "R6"; end
    if (t < 0)     begin t = 0;     m_lo = 1'b1; tag = "R7"; end
    m_total = t;
    @(negedge clk);
    corr_valid  = 1'b1;
    corr_up     = up;
    corr_coarse = coarse;
    @(negedge clk);
    corr_valid = 1'b0;
    check(tag);
  endtask

  task automatic t_reset;
    m_total = 128; m_hi = 0; m_lo = 0;
    check("R1");
  endtask

  task automatic t_fine;
    apply(1, 0); apply(1, 0); apply(1, 0);
    apply(0, 0); apply(0, 0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      corr_up = i[0];
      corr_coarse = i[1];
    end
    check("R8");
  endtask

  task automatic t_coarse_carry;
    apply(1, 1); apply(1, 1); apply(1, 1);
    apply(0, 1); apply(0, 0); apply(0, 1);
  endtask

  task automatic t_sat_high;
    for (int i = 0; i < 120 && !m_hi; i++) apply(1, 1);
    apply(1, 1);
    apply(1, 0);
    n_checks++;
    if (div_code > 4'd9) begin
      n_fail++;
      $display("FAIL R9: got div=%0d, expected at most 9", div_code);
    end
    t_idle();
    apply(0, 0);
    check("R8");
  endtask

  task automatic t_sat_low;
    for (int i = 0; i < 120 && !m_lo; i++) apply(0, 1);
    apply(0, 1);
    apply(0, 0);
    t_idle();
    apply(1, 1);
    check("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fine();
    t_idle();
    t_coarse_carry();
    t_sat_high();
    t_sat_low();
    t_fine();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule